// File: doc/BRIEF.md
# DMA Address Translation Map

This block is the page map a DMA engine consults before every memory access. It holds 256 entries, one for each 512-byte page of a 17-bit transfer address space. Each entry is a valid flag plus a 21-bit page frame number. Software fills the table through a word-addressed host port. The DMA engine sends a virtual address and, one cycle later, gets back either a physical address or a failure.

Each lookup also leaves its raw entry in a read-only selected-entry register, so software can see which mapping was last used. A lookup that lands on an entry with the valid bit clear produces no address. Instead it sets a sticky invalid-map flag, which the surrounding adapter treats as an abort-class error.

A full reset wipes the table. A soft init clears only the selected-entry register and the flag, and leaves the table contents in place.

Top module: `dma_xlate_map`

## Requirements
- R1: The table has 256 entries. A host write keeps data bit 31 as the valid flag and bits [20:0] as the page frame number. A read of that entry returns those bits, with every other bit read as zero.
- R2: The host entry index is host address bits [9:2]. Host address bits [1:0] have no effect on which entry is written or read.
- R3: A lookup of an entry whose valid bit is set returns lk_ok=1 and lk_pa = (frame << 9) + lk_va[8:0]. The entry index is lk_va[16:9], so the two ends of the range select entries 0 and 255.
- R4: Every accepted lookup copies the stored entry into sel_entry, whether the entry is valid or not, using the same layout as a host read. sel_entry does not change in a cycle with no lookup, including when the host rewrites the entry it came from.
- R5: The lookup result is registered. lk_done is high exactly in the cycle after an accepted lk_req, and lk_ok and lk_pa are valid in that cycle.
- R6: A lookup of an entry whose valid bit is clear returns lk_ok=0 and lk_pa=0, and sets the sticky invm_flag.
- R7: Full reset (rst_n low) clears every table entry, sel_entry, invm_flag and lk_done.
- R8: A soft_init pulse clears sel_entry and invm_flag and keeps all table entries. A lookup requested in the same cycle as soft_init is dropped, so lk_done stays low.
- R9: When a host write and a lookup hit the same entry in the same cycle, the lookup uses the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low full reset; clears the table |
| soft_init | input | 1 | Clears selected entry and flag; table kept |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 10 | Host byte address; bits [9:2] select the entry |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Entry at host_addr (combinational) |
| lk_req | input | 1 | Lookup request |
| lk_va | input | 17 | Transfer virtual address |
| lk_done | output | 1 | Lookup result valid |
| lk_ok | output | 1 | Entry was valid |
| lk_pa | output | 30 | Translated physical address |
| sel_entry | output | 32 | Last entry used by a lookup |
| invm_flag | output | 1 | Sticky invalid-map error |

## Verification
Host reads are combinational and are checked in the same cycle that host_addr is driven. A write is checked at least one edge after it is presented. Lookup results, sel_entry and invm_flag take effect at the first rising edge after lk_req, so the bench drives each request on a falling edge and checks on the next falling edge, while lk_done is high. It then checks one cycle later that lk_done has dropped and sel_entry has held. The same-cycle cases (a write racing a lookup, and soft_init racing a lookup) are driven on one edge and checked at that same single-cycle distance.

// File: rtl/dma_xlate_map.sv
module dma_xlate_map #(
  parameter int VA_W       = 17,
  parameter int PAGE_SHIFT = 9,
  parameter int PFN_W      = 21,
  localparam int IDX_W     = VA_W - PAGE_SHIFT,
  localparam int ENTRIES   = 1 << IDX_W,
  localparam int HA_W      = IDX_W + 2,
  localparam int PA_W      = PFN_W + PAGE_SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_init,
  input  logic             host_we,
  input  logic [HA_W-1:0]  host_addr,
  input  logic [31:0]      host_wdata,
  output logic [31:0]      host_rdata,
  input  logic             lk_req,
  input  logic [VA_W-1:0]  lk_va,
  output logic             lk_done,
  output logic             lk_ok,
  output logic [PA_W-1:0]  lk_pa,
  output logic [31:0]      sel_entry,
  output logic             invm_flag
);

  logic [PFN_W:0] map_q [ENTRIES];
  logic [PFN_W:0] sel_q;
  logic [IDX_W-1:0] hidx, lidx;
  logic [PFN_W:0] lk_ent;

  function automatic logic [31:0] widen(input logic [PFN_W:0] e);
    widen = {e[PFN_W], {(31-PFN_W){1'b0}}, e[PFN_W-1:0]};
  endfunction

  assign hidx       = host_addr[HA_W-1:2];
  assign lidx       = lk_va[VA_W-1:PAGE_SHIFT];
  assign lk_ent     = map_q[lidx];
  assign host_rdata = widen(map_q[hidx]);
  assign sel_entry  = widen(sel_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) map_q[i] <= '0;
      sel_q     <= '0;
      invm_flag <= 1'b0;
      lk_done   <= 1'b0;
      lk_ok     <= 1'b0;
      lk_pa     <= '0;
    end else begin
      if (host_we) map_q[hidx] <= {host_wdata[31], host_wdata[PFN_W-1:0]};
      lk_done <= lk_req && !soft_init;
      if (soft_init) begin
        sel_q     <= '0;
        invm_flag <= 1'b0;
        lk_ok     <= 1'b0;
        lk_pa     <= '0;
      end else if (lk_req) begin
        sel_q <= lk_ent;
        lk_ok <= lk_ent[PFN_W];
        if (lk_ent[PFN_W]) begin
          lk_pa <= {lk_ent[PFN_W-1:0], lk_va[PAGE_SHIFT-1:0]};
        end else begin
          lk_pa     <= '0;
          invm_flag <= 1'b1;
        end
      end
    end
  end

  p_done_after_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && !soft_init) |=> lk_done);
  p_done_only_after_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_req && !soft_init) |=> !lk_done);
  p_ok_tracks_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lk_done |-> (lk_ok == sel_entry[31]));
  p_offset_passthru_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_done && lk_ok) |-> (lk_pa[PAGE_SHIFT-1:0] == $past(lk_va[PAGE_SHIFT-1:0])));
  p_frame_from_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_done && lk_ok) |-> (lk_pa[PA_W-1:PAGE_SHIFT] == sel_entry[PFN_W-1:0]));
  p_fail_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_done && !lk_ok) |-> (invm_flag && lk_pa == '0));
  p_sel_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!lk_req && !soft_init) |=> $stable(sel_entry));
  p_init_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    soft_init |=> (!invm_flag && sel_entry == '0));
  p_rdata_mask_r1: assert property (@(posedge clk) disable iff (!rst_n)
    host_rdata[30:PFN_W] == '0);

endmodule

// File: tb/dma_xlate_map_tb.sv
module dma_xlate_map_tb;
  logic clk = 0, rst_n = 0, soft_init = 0, host_we = 0, lk_req = 0;
  logic [9:0] host_addr = 0;
  logic [31:0] host_wdata = 0, host_rdata, sel_entry;
  logic [16:0] lk_va = 0;
  logic lk_done, lk_ok, invm_flag;
  logic [29:0] lk_pa;
  int nchk = 0, nbad = 0;
  logic [31:0] model [256];

  dma_xlate_map u_dut (.clk, .rst_n, .soft_init, .host_we, .host_addr, .host_wdata,
    .host_rdata, .lk_req, .lk_va, .lk_done, .lk_ok, .lk_pa, .sel_entry, .invm_flag);

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] keep(input logic [31:0] d);
    keep = d & 32'h801F_FFFF;
  endfunction

  task automatic hwrite(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk); host_we = 1; host_addr = a; host_wdata = d;
    @(negedge clk); host_we = 0;
    model[a[9:2]] = keep(d);
  endtask

  task automatic hread(input string req, input logic [9:0] a, input logic [31:0] exp);
    @(negedge clk); host_addr = a; #1;
    chk(req, host_rdata, exp);
  endtask

  task automatic lookup(input string req, input logic [16:0] va);
    logic [31:0] e;
    logic [29:0] epa;
    e = model[va[16:8+1]];
    epa = e[31] ? {e[20:0], va[8:0]} : 30'd0;
    @(negedge clk); lk_req = 1; lk_va = va;
    @(negedge clk); lk_req = 0;
    chk({req, " done"}, {31'd0, lk_done}, 1);
    chk({req, " ok"}, {31'd0, lk_ok}, {31'd0, e[31]});
    chk({req, " pa"}, {2'd0, lk_pa}, {2'd0, epa});
    chk({req, " sel"}, sel_entry, e);
    @(negedge clk);
    chk({req, " done drop R5"}, {31'd0, lk_done}, 0);
  endtask

  task automatic t_reset;
    chk("R7 sel", sel_entry, 0);
    chk("R7 flag", {31'd0, invm_flag}, 0);
    chk("R7 done", {31'd0, lk_done}, 0);
    hread("R7 entry", 10'h014, 0);
  endtask

  task automatic t_hostport;
    hwrite(10'h3FF, 32'hFFFF_FFFF);
    hread("R1 mask", 10'h3FC, 32'h801F_FFFF);
    hwrite(10'h009, 32'h1234_5678);
    hread("R2 low bits", 10'h008, keep(32'h1234_5678));
    hread("R2 neighbour", 10'h00C, 0);
  endtask

  task automatic t_valid;
    hwrite({8'h52, 2'b00}, 32'hFFE0_1234);
    lookup("R3 mid", 17'h0A5C3);
    hwrite(10'h000, 32'h8000_0007);
    lookup("R3 low end", 17'h00000);
    lookup("R3 high end", 17'h1FFFF);
    chk("R6 no flag", {31'd0, invm_flag}, 0);
  endtask

  task automatic t_invalid;
    hwrite({8'h10, 2'b00}, 32'h0012_3456);
    lookup("R6 invalid", 17'h02055);
    chk("R6 flag", {31'd0, invm_flag}, 1);
    hwrite({8'h10, 2'b00}, 32'h8000_0001);
    @(negedge clk);
    chk("R4 sel hold", sel_entry, keep(32'h0012_3456));
    lookup("R6 flag sticky", 17'h0A400);
    chk("R6 flag stays", {31'd0, invm_flag}, 1);
  endtask

  task automatic t_race;
    logic [31:0] old;
    old = model[8'h52];
    @(negedge clk); host_we = 1; host_addr = {8'h52, 2'b00}; host_wdata = 32'h8000_0AAA;
    lk_req = 1; lk_va = 17'h0A401;
    @(negedge clk); host_we = 0; lk_req = 0;
    model[8'h52] = keep(32'h8000_0AAA);
    chk("R9 sel old", sel_entry, old);
    chk("R9 pa old", {2'd0, lk_pa}, {2'd0, old[20:0], 9'h001});
    hread("R9 written", {8'h52, 2'b00}, 32'h8000_0AAA);
  endtask

  task automatic t_soft;
    @(negedge clk); soft_init = 1; lk_req = 1; lk_va = 17'h0A400;
    @(negedge clk); soft_init = 0; lk_req = 0;
    chk("R8 dropped", {31'd0, lk_done}, 0);
    chk("R8 flag", {31'd0, invm_flag}, 0);
    chk("R8 sel", sel_entry, 0);
    hread("R8 map kept", {8'h52, 2'b00}, 32'h8000_0AAA);
  endtask

  task automatic t_fullreset;
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    for (int i = 0; i < 256; i++) model[i] = 0;
    hread("R7 cleared a", {8'h52, 2'b00}, 0);
    hread("R7 cleared b", 10'h3FC, 0);
    lookup("R7 post", 17'h1FFFF);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) model[i] = 0;
    repeat (2) @(negedge clk);
    t_reset;
    rst_n = 1;
    t_hostport;
    t_valid;
    t_invalid;
    t_race;
    t_soft;
    t_fullreset;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule